// File: doc/BRIEF.md
# Cache Injection Window Table

This block sits beside a private cache and lets it pick up shared lines that it never asked for. Software declares address windows that the local processor expects to consume. A window is opened in two steps: one command records the lower bound and a second one supplies the upper bound and commits the window into a free slot. A window is closed by naming its lower bound again. While windows are open, the table watches every data transfer on the shared bus. It looks for fills that answer another cache's read miss and for update transfers pushed out by a producer. When such a transfer falls inside an open window, the table tells the cache controller to install the line in Shared state.

A two-state command machine holds the opening sequence. In state IDLE no lower bound is pending. An open-low command moves it to LOW_PEND. In LOW_PEND a further open-low replaces the pending bound and leaves the state unchanged. An open-high command returns it to IDLE: it either commits the window, or drops it and pulses the overflow output when every slot is taken. An open-high command seen in IDLE does nothing. Close commands act in either state and do not change it. All slots are compared with the snoop address in parallel, and the injection request is registered.

Top module: `cinj_window_table`

## Requirements
- R1: After reset no window is open, `inj_valid` and `open_overflow` are low, and no snoop transfer causes an injection.
- R2: An open-low command (`cmd_op`=01) followed by an open-high command (`cmd_op`=10) opens a window that covers the line addresses from the low bound to the high bound, both bounds included. The window applies to snoops sampled on later clock edges, not to a snoop sampled on the same edge as the open-high.
- R3: An open-high command given while no lower bound is pending is ignored: it opens no window and raises no overflow.
- R4: A second open-low command given while a lower bound is pending replaces that bound.
- R5: A close command (`cmd_op`=11) invalidates every open window whose lower bound equals the line of `cmd_addr` and leaves all other windows unchanged.
- R6: A read-response snoop (`snp_kind`=01) inside an open window raises `inj_valid` one cycle later. In that cycle `inj_addr` is the line-aligned snoop address and `inj_data` is the snoop data. `inj_valid` means "install this line as Shared".
- R7: An update snoop (`snp_kind`=10) inside an open window is injected in the same way.
- R8: Snoop kinds 00 and 11 never cause an injection.
- R9: A snoop whose `snp_src` equals the parameter `MY_ID` is never injected.
- R10: A snoop that arrives with `snp_local_hit` high is never injected.
- R11: A snoop line below the low bound or above the high bound of every open window is not injected.
- R12: An open-high command in LOW_PEND while all slots are valid opens no window, pulses `open_overflow` for one cycle after the command edge, and clears the pending bound.
- R13: Bounds and snoop addresses are compared at line granularity. The low `log2(LINE_BYTES)` address bits (5 by default) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 00 none, 01 open low, 10 open high, 11 close |
| cmd_addr | input | ADDR_W | Byte address carried by the command |
| snp_valid | input | 1 | A bus data transfer is present this cycle |
| snp_kind | input | 2 | 00 other, 01 read response, 10 update, 11 write-back |
| snp_addr | input | ADDR_W | Byte address of the transfer |
| snp_src | input | SRC_W | Identifier of the cache that issued the transfer |
| snp_data | input | LINE_BYTES*8 | Line data on the bus |
| snp_local_hit | input | 1 | The line is already held by the local cache |
| inj_valid | output | 1 | Install the captured line in Shared state |
| inj_addr | output | ADDR_W | Line-aligned address of the captured line |
| inj_data | output | LINE_BYTES*8 | Captured line data |
| open_overflow | output | 1 | One-cycle pulse when a window open was dropped |

## Verification
A command takes effect on the edge that samples it. A window therefore first matches a snoop sampled one edge after the open-high, and the bench drives exactly that overlap to confirm that the same-edge snoop misses. The injection request and the overflow pulse each come from one register stage. Both are due in the cycle after the edge that sampled the snoop or the command. The bench drives inputs just after a rising edge and compares the outputs one time unit after the following edge against a behavioural model that has been advanced by that same edge.

// File: rtl/cinj_pkg.sv
package cinj_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_OPEN_LO = 2'b01,
        CMD_OPEN_HI = 2'b10,
        CMD_CLOSE   = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SNP_OTHER   = 2'b00,
        SNP_RD_RESP = 2'b01,
        SNP_UPDATE  = 2'b10,
        SNP_WRBACK  = 2'b11
    } snp_e;

    typedef enum logic {
        FSM_IDLE     = 1'b0,
        FSM_LOW_PEND = 1'b1
    } fsm_e;

endpackage

// File: rtl/cinj_cmd_fsm.sv
module cinj_cmd_fsm
    import cinj_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic              free_found,
    input  logic [IDX_W-1:0]  free_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [LINE_W-1:0] wr_lo,
    output logic [LINE_W-1:0] wr_hi,
    output logic              close_en,
    output logic [LINE_W-1:0] close_lo,
    output logic              ovf_q
);

    fsm_e              state, state_nx;
    cmd_e              op;
    logic [LINE_W-1:0] pend_lo;
    logic              drop;

    assign op = cmd_e'(cmd_op);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            FSM_IDLE:     if (op == CMD_OPEN_LO) state_nx = FSM_LOW_PEND;
            FSM_LOW_PEND: if (op == CMD_OPEN_HI) state_nx = FSM_IDLE;
        endcase
    end

    // state register with pending bound and overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FSM_IDLE;
            pend_lo <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state <= state_nx;
            ovf_q <= drop;
            if (op == CMD_OPEN_LO) pend_lo <= cmd_line;
        end
    end

    // outputs toward the window array
    always_comb begin
        wr_en    = 1'b0;
        drop     = 1'b0;
        wr_idx   = free_idx;
        wr_lo    = pend_lo;
        wr_hi    = cmd_line;
        close_en = (op == CMD_CLOSE);
        close_lo = cmd_line;
        unique case (state)
            FSM_IDLE: ;
            FSM_LOW_PEND: begin
                if (op == CMD_OPEN_HI) begin
                    wr_en = free_found;
                    drop  = !free_found;
                end
            end
        endcase
    end

    // R12: overflow only ever follows an open-high taken while a bound was pending
    a_r12_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(cmd_op) == CMD_OPEN_HI && $past(state) == FSM_LOW_PEND));

    // R3: open-high while idle never produces an overflow
    a_r3_idle_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FSM_IDLE && op == CMD_OPEN_HI) |=> !ovf_q);

    // R3: a slot is written only out of the pending state
    a_r3_write_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state == FSM_LOW_PEND);

endmodule

// File: rtl/cinj_window_array.sv
module cinj_window_array #(
    parameter int ENTRIES = 128,
    parameter int LINE_W  = 27,
    parameter int IDX_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_lo,
    input  logic [LINE_W-1:0] wr_hi,
    input  logic              close_en,
    input  logic [LINE_W-1:0] close_lo,
    input  logic [LINE_W-1:0] q_line,
    output logic              q_hit,
    output logic              free_found,
    output logic [IDX_W-1:0]  free_idx
);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic [LINE_W-1:0]  lo_q [ENTRIES];
    logic [LINE_W-1:0]  hi_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
            end else if (sel) begin
                valid_vec[i] <= 1'b1;
            end else if (close_en && valid_vec[i] && lo_q[i] == close_lo) begin
                valid_vec[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                lo_q[i] <= wr_lo;
                hi_q[i] <= wr_hi;
            end
        end

        assign hit_vec[i] = valid_vec[i] && (q_line >= lo_q[i]) && (q_line <= hi_q[i]);

        // R5: a close naming this slot's low bound leaves it invalid
        a_r5_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (close_en && !sel && lo_q[i] == close_lo) |=> !valid_vec[i]);
    end

    assign q_hit = |hit_vec;

    // lowest free slot wins
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // R2: a committed window is valid on the next cycle
    a_r2_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/cinj_snoop_filter.sv
module cinj_snoop_filter
    import cinj_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int DATA_W = 256,
    parameter int SRC_W  = 4,
    parameter int MY_ID  = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snp_valid,
    input  logic [1:0]               snp_kind,
    input  logic [ADDR_W-OFFS_W-1:0] snp_line,
    input  logic [SRC_W-1:0]         snp_src,
    input  logic [DATA_W-1:0]        snp_data,
    input  logic                     local_hit,
    input  logic                     win_hit,
    output logic                     inj_valid,
    output logic [ADDR_W-1:0]        inj_addr,
    output logic [DATA_W-1:0]        inj_data
);

    snp_e kind;
    logic kind_ok;
    logic fire;

    assign kind    = snp_e'(snp_kind);
    assign kind_ok = (kind == SNP_RD_RESP) || (kind == SNP_UPDATE);
    assign fire    = snp_valid && kind_ok && win_hit && !local_hit
                     && (snp_src != SRC_W'(MY_ID));

    always_ff @(posedge clk) begin
        if (!rst_n) inj_valid <= 1'b0;
        else        inj_valid <= fire;
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            inj_addr <= {snp_line, {OFFS_W{1'b0}}};
            inj_data <= snp_data;
        end
    end

    // R6: an injection always answers a sampled transfer of a capturable kind
    a_r6_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> ($past(snp_valid) && $past(win_hit)));

    // R8: other kinds are never captured
    a_r8_kind_filter: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> ($past(snp_kind) == SNP_RD_RESP || $past(snp_kind) == SNP_UPDATE));

    // R9: own transfers are never captured
    a_r9_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> ($past(snp_src) != SRC_W'(MY_ID)));

    // R10: lines already held are never captured
    a_r10_not_present: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !$past(local_hit));

endmodule

// File: rtl/cinj_window_table.sv
module cinj_window_table #(
    parameter int ENTRIES    = 128,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SRC_W      = 4,
    parameter int MY_ID      = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cmd_op,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic                      snp_valid,
    input  logic [1:0]                snp_kind,
    input  logic [ADDR_W-1:0]         snp_addr,
    input  logic [SRC_W-1:0]          snp_src,
    input  logic [LINE_BYTES*8-1:0]   snp_data,
    input  logic                      snp_local_hit,
    output logic                      inj_valid,
    output logic [ADDR_W-1:0]         inj_addr,
    output logic [LINE_BYTES*8-1:0]   inj_data,
    output logic                      open_overflow
);

    localparam int OFFS_W = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFFS_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int DATA_W = LINE_BYTES * 8;

    logic              wr_en, close_en, free_found, win_hit;
    logic [IDX_W-1:0]  wr_idx, free_idx;
    logic [LINE_W-1:0] wr_lo, wr_hi, close_lo;

    cinj_cmd_fsm #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_addr[ADDR_W-1:OFFS_W]),
        .free_found (free_found),
        .free_idx   (free_idx),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .close_en   (close_en),
        .close_lo   (close_lo),
        .ovf_q      (open_overflow)
    );

    cinj_window_array #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .close_en   (close_en),
        .close_lo   (close_lo),
        .q_line     (snp_addr[ADDR_W-1:OFFS_W]),
        .q_hit      (win_hit),
        .free_found (free_found),
        .free_idx   (free_idx)
    );

    cinj_snoop_filter #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .DATA_W (DATA_W),
        .SRC_W  (SRC_W),
        .MY_ID  (MY_ID)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_kind  (snp_kind),
        .snp_line  (snp_addr[ADDR_W-1:OFFS_W]),
        .snp_src   (snp_src),
        .snp_data  (snp_data),
        .local_hit (snp_local_hit),
        .win_hit   (win_hit),
        .inj_valid (inj_valid),
        .inj_addr  (inj_addr),
        .inj_data  (inj_data)
    );

    // R1/R12: overflow and injection stay quiet during reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!inj_valid && !open_overflow));

endmodule

// File: tb/cinj_window_table_test.sv
module cinj_window_table_test;

    localparam int NE = 4;
    localparam int ME = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   cmd_op;
    logic [31:0]  cmd_addr;
    logic         snp_valid;
    logic [1:0]   snp_kind;
    logic [31:0]  snp_addr;
    logic [1:0]   snp_src;
    logic [255:0] snp_data;
    logic         snp_local_hit;
    logic         inj_valid;
    logic [31:0]  inj_addr;
    logic [255:0] inj_data;
    logic         open_overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_v [NE];
    logic [26:0] m_lo [NE];
    logic [26:0] m_hi [NE];
    bit          m_pend;
    logic [26:0] m_plo;

    always #5 clk = ~clk;

    cinj_window_table #(.ENTRIES(NE), .ADDR_W(32), .LINE_BYTES(32), .SRC_W(2), .MY_ID(ME)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .snp_src(snp_src), .snp_data(snp_data), .snp_local_hit(snp_local_hit),
        .inj_valid(inj_valid), .inj_addr(inj_addr), .inj_data(inj_data),
        .open_overflow(open_overflow)
    );

    task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [26:0] ln);
        for (int i = 0; i < NE; i++)
            if (m_v[i] && ln >= m_lo[i] && ln <= m_hi[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input logic [1:0] op, input logic [31:0] ca, input logic sv,
                        input logic [1:0] kd, input logic [31:0] sa, input logic [1:0] src,
                        input logic pres, input logic [255:0] d, input string tag);
        bit e_inj, e_ovf, placed;
        logic [26:0] cl;
        cmd_op = op; cmd_addr = ca; snp_valid = sv; snp_kind = kd; snp_addr = sa;
        snp_src = src; snp_local_hit = pres; snp_data = d;
        @(posedge clk); #1;
        e_inj = sv && (kd == 2'b01 || kd == 2'b10) && src != 2'(ME) && !pres && m_hit(sa[31:5]);
        e_ovf = 1'b0;
        cl = ca[31:5];
        case (op)
            2'b01: begin m_pend = 1'b1; m_plo = cl; end
            2'b10: if (m_pend) begin
                placed = 1'b0;
                for (int i = 0; i < NE; i++)
                    if (!placed && !m_v[i]) begin
                        m_v[i] = 1'b1; m_lo[i] = m_plo; m_hi[i] = cl; placed = 1'b1;
                    end
                e_ovf = !placed;
                m_pend = 1'b0;
            end
            2'b11: for (int i = 0; i < NE; i++)
                if (m_v[i] && m_lo[i] == cl) m_v[i] = 1'b0;
            default: ;
        endcase
        chk(tag, "inj_valid", 256'(inj_valid), 256'(e_inj));
        chk(tag, "open_overflow", 256'(open_overflow), 256'(e_ovf));
        if (e_inj) begin
            chk(tag, "inj_addr", 256'(inj_addr), 256'({sa[31:5], 5'b0}));
            chk(tag, "inj_data", inj_data, d);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] ca, input string tag);
        step(op, ca, 1'b0, 2'b00, 32'h0, 2'd0, 1'b0, '0, tag);
    endtask

    task automatic snp(input logic [1:0] kd, input logic [31:0] sa, input logic [1:0] src,
                       input logic pres, input string tag);
        step(2'b00, 32'h0, 1'b1, kd, sa, src, pres, {8{sa ^ 32'hA5C3_0F1E}}, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_v[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; end
        m_pend = 1'b0; m_plo = '0;
        rst_n = 1'b0; cmd_op = 2'b00; cmd_addr = '0; snp_valid = 1'b0; snp_kind = 2'b00;
        snp_addr = '0; snp_src = '0; snp_data = '0; snp_local_hit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "inj_valid in reset", 256'(inj_valid), 256'(0));
        chk("R1", "open_overflow in reset", 256'(open_overflow), 256'(0));
        rst_n = 1'b1;
        snp(2'b01, 32'h0000_1000, 2'd0, 1'b0, "R1");
        snp(2'b10, 32'hFFFF_FFE0, 2'd1, 1'b0, "R1");

        // R3: lone open-high, then a proper open
        cmd(2'b10, 32'h0000_1FE0, "R3");
        snp(2'b01, 32'h0000_1000, 2'd0, 1'b0, "R3");
        cmd(2'b01, 32'h0000_1000, "R2");
        // R2: same-edge snoop misses, next one hits
        step(2'b10, 32'h0000_1FE0, 1'b1, 2'b01, 32'h0000_1400, 2'd0, 1'b0, {8{32'h1234_5678}}, "R2");
        snp(2'b01, 32'h0000_1400, 2'd0, 1'b0, "R2");

        snp(2'b01, 32'h0000_1000, 2'd1, 1'b0, "R6");
        snp(2'b10, 32'h0000_1FE0, 2'd3, 1'b0, "R7");
        snp(2'b10, 32'h0000_1FFF, 2'd0, 1'b0, "R13");
        snp(2'b01, 32'h0000_100C, 2'd0, 1'b0, "R13");
        snp(2'b01, 32'h0000_2000, 2'd0, 1'b0, "R11");
        snp(2'b01, 32'h0000_0FE0, 2'd0, 1'b0, "R11");
        snp(2'b00, 32'h0000_1200, 2'd0, 1'b0, "R8");
        snp(2'b11, 32'h0000_1200, 2'd0, 1'b0, "R8");
        snp(2'b01, 32'h0000_1200, 2'(ME), 1'b0, "R9");
        snp(2'b10, 32'h0000_1200, 2'(ME), 1'b0, "R9");
        snp(2'b01, 32'h0000_1200, 2'd1, 1'b1, "R10");
        snp(2'b01, 32'h0000_1220, 2'd1, 1'b0, "R6");

        // R4: replaced pending low bound
        cmd(2'b01, 32'h0000_5000, "R4");
        cmd(2'b01, 32'h0000_6000, "R4");
        cmd(2'b10, 32'h0000_6FE0, "R4");
        snp(2'b01, 32'h0000_5000, 2'd0, 1'b0, "R4");
        snp(2'b01, 32'h0000_6000, 2'd0, 1'b0, "R4");

        // R5: a second window sharing the low bound, then close both
        cmd(2'b01, 32'h0000_1000, "R5");
        cmd(2'b10, 32'h0000_3000, "R5");
        snp(2'b01, 32'h0000_2800, 2'd0, 1'b0, "R5");
        cmd(2'b11, 32'h0000_1010, "R5");
        snp(2'b01, 32'h0000_1000, 2'd0, 1'b0, "R5");
        snp(2'b01, 32'h0000_2800, 2'd0, 1'b0, "R5");
        snp(2'b10, 32'h0000_6100, 2'd0, 1'b0, "R5");

        // R12: fill the table, then overflow
        for (int k = 0; k < 3; k++) begin
            cmd(2'b01, 32'h0010_0000 + 32'(k) * 32'h1000, "R12");
            cmd(2'b10, 32'h0010_0FE0 + 32'(k) * 32'h1000, "R12");
        end
        snp(2'b01, 32'h0010_2040, 2'd0, 1'b0, "R12");
        cmd(2'b01, 32'h0020_0000, "R12");
        cmd(2'b10, 32'h0020_0FE0, "R12");
        cmd(2'b00, 32'h0, "R12");
        snp(2'b01, 32'h0020_0100, 2'd0, 1'b0, "R12");
        cmd(2'b10, 32'h0020_0FE0, "R12");
        cmd(2'b00, 32'h0, "R3");

        // free one slot and reuse it
        cmd(2'b11, 32'h0000_6000, "R5");
        cmd(2'b01, 32'h0030_0000, "R2");
        cmd(2'b10, 32'h0030_0000, "R2");
        snp(2'b10, 32'h0030_001F, 2'd1, 1'b0, "R13");
        snp(2'b10, 32'h0030_0020, 2'd1, 1'b0, "R11");
        snp(2'b00, 32'h0, 2'd0, 1'b0, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule